// File: doc/BRIEF.md
# Selectable-Algorithm SRAM Self-Test Sequencer

This block tests a synchronous single-port SRAM of 256 words by 4 bits without any software help. When reset is released it samples a 3-bit algorithm code once. It then drives address, write data and write enable into the memory, one operation per clock, until the chosen algorithm is complete. Every read is checked against the value the algorithm expects, one cycle after the read address was presented. The first wrong word sets a sticky fail flag and records its address. At the end the block raises `done` and hands the memory port to the functional interface, which from then on passes straight through to the memory. Read data from the memory goes to the functional logic directly and does not pass through this block.

Each algorithm is a list of elements. An element has an address direction and one to four operations, and all of its operations are applied to one address before the sequencer moves to the next. The sequencer has four states:
- IDLE: the reset state. It samples the code and always moves to RUN on the next edge.
- RUN: issues one operation per cycle. After the last operation of the final element it moves to DRAIN.
- DRAIN: the final read is compared. It always moves to DONE.
- DONE: terminal until reset. It gives the port to the functional side.

Top module: `sram_bist_ctrl`

## Requirements
- R1: While `rst_n` is low, `done` and `fail` are 0 and `mem_we` is 0, whatever the functional inputs carry.
- R2: The first rising edge with `rst_n` high samples `alg_sel`, and the first test operation appears on the memory port in the following cycle. Changes of `alg_sel` after that edge have no effect until the next reset.
- R3: Code 0 writes 4'b0000 to addresses 0 to 255 in ascending order, one per cycle, then reads them back in ascending order (`mem_we`=0). Code 1 does the same with 4'b1111.
- R4: Code 2 writes 4'b0101 to even and 4'b1010 to odd addresses in ascending order, then reads them back in ascending order with the same expectation. Code 3 swaps the two words.
- R5: Code 4 runs these elements in order: up(w0); up(r0,w1); up(r1,w0); down(r0,w1); down(r1,w0); up(r0). Here 0 means 4'b0000 and 1 means 4'b1111. Up runs from 0 to 255 and down from 255 to 0, and every operation of an element is applied at one address before the next address.
- R6: Code 5 runs these elements in order: up(w0); down(r0,w1); up(r1,w0,r0,w1); up(r1,w0); up(r0,w1,r1,w0); up(r0), with the same conventions as R5.
- R7: Codes 6 and 7 behave exactly like code 0.
- R8: The word on `mem_rdata` one cycle after a read address was issued is compared with the expected word for that operation.
- R9: The first mismatch, in operation order, sets `fail`, and `fail_addr` takes its address. Later mismatches change neither, and `fail` stays high until reset.
- R10: `done` is low during the run and rises two cycles after the last read is issued, in the same cycle as the final `fail` value. It then stays high until reset.
- R11: While `done` is high, `mem_addr`, `mem_wdata` and `mem_we` equal `fn_addr`, `fn_wdata` and `fn_we` in the same cycle, so the memory can be written and read by the functional side.
- R12: Before `done`, the functional inputs have no effect on the memory port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; restarts the test |
| alg_sel | input | 3 | Algorithm code, sampled once after reset |
| fn_addr | input | AW (8) | Functional address |
| fn_wdata | input | DW (4) | Functional write data |
| fn_we | input | 1 | Functional write enable |
| mem_rdata | input | DW (4) | Read data from the memory, one cycle after the address |
| mem_addr | output | AW (8) | Address to the memory |
| mem_wdata | output | DW (4) | Write data to the memory |
| mem_we | output | 1 | Write enable to the memory |
| done | output | 1 | Test complete and port handed back |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | AW (8) | Address of the first mismatch |

## Verification
The hardest case to reach from the ports is the first-mismatch latch when two faulty cells exist. Which one fails first depends on the element order and on the address direction, not on which address is lower. The bench's memory model takes stuck-at bits at chosen cells. In one March LR run it places faults at addresses 5 and 250, so the descending second element must report 250 first. Another pair of runs sets a stuck bit that agrees with the checkerboard word at an odd address, which must go unreported, and then with the inverse word, which must be reported.

// File: rtl/sbist_pkg.sv
package sbist_pkg;

    typedef enum logic [1:0] {BG_ZERO, BG_ONE, BG_CHK, BG_ICHK} bg_e;

    typedef struct packed {
        logic wr;
        bg_e  bg;
    } op_t;

    typedef struct packed {
        logic       down;
        logic [1:0] last_op;
        logic       final_el;
        op_t [3:0]  ops;
    } elem_t;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN, ST_DONE} st_e;

    function automatic op_t op_w(input bg_e b);
        op_t o;
        o.wr = 1'b1;
        o.bg = b;
        return o;
    endfunction

    function automatic op_t op_r(input bg_e b);
        op_t o;
        o.wr = 1'b0;
        o.bg = b;
        return o;
    endfunction

    function automatic elem_t elem_lookup(input logic [2:0] alg, input logic [2:0] idx);
        elem_t e;
        bg_e   b;
        e = '0;
        case (alg)
            3'd1:    b = BG_ONE;
            3'd2:    b = BG_CHK;
            3'd3:    b = BG_ICHK;
            default: b = BG_ZERO;
        endcase
        case (alg)
            3'd4: begin
                case (idx)
                    3'd0: e.ops[0] = op_w(BG_ZERO);
                    3'd1: begin
                        e.last_op = 2'd1;
                        e.ops[0] = op_r(BG_ZERO);
                        e.ops[1] = op_w(BG_ONE);
                    end
                    3'd2: begin
                        e.last_op = 2'd1;
                        e.ops[0] = op_r(BG_ONE);
                        e.ops[1] = op_w(BG_ZERO);
                    end
                    3'd3: begin
                        e.down = 1'b1;
                        e.last_op = 2'd1;
                        e.ops[0] = op_r(BG_ZERO);
                        e.ops[1] = op_w(BG_ONE);
                    end
                    3'd4: begin
                        e.down = 1'b1;
                        e.last_op = 2'd1;
                        e.ops[0] = op_r(BG_ONE);
                        e.ops[1] = op_w(BG_ZERO);
                    end
                    default: begin
                        e.final_el = 1'b1;
                        e.ops[0] = op_r(BG_ZERO);
                    end
                endcase
            end
            3'd5: begin
                case (idx)
                    3'd0: e.ops[0] = op_w(BG_ZERO);
                    3'd1: begin
                        e.down = 1'b1;
                        e.last_op = 2'd1;
                        e.ops[0] = op_r(BG_ZERO);
                        e.ops[1] = op_w(BG_ONE);
                    end
                    3'd2: begin
                        e.last_op = 2'd3;
                        e.ops[0] = op_r(BG_ONE);
                        e.ops[1] = op_w(BG_ZERO);
                        e.ops[2] = op_r(BG_ZERO);
                        e.ops[3] = op_w(BG_ONE);
                    end
                    3'd3: begin
                        e.last_op = 2'd1;
                        e.ops[0] = op_r(BG_ONE);
                        e.ops[1] = op_w(BG_ZERO);
                    end
                    3'd4: begin
                        e.last_op = 2'd3;
                        e.ops[0] = op_r(BG_ZERO);
                        e.ops[1] = op_w(BG_ONE);
                        e.ops[2] = op_r(BG_ONE);
                        e.ops[3] = op_w(BG_ZERO);
                    end
                    default: begin
                        e.final_el = 1'b1;
                        e.ops[0] = op_r(BG_ZERO);
                    end
                endcase
            end
            default: begin
                if (idx == 3'd0) begin
                    e.ops[0] = op_w(b);
                end else begin
                    e.final_el = 1'b1;
                    e.ops[0] = op_r(b);
                end
            end
        endcase
        return e;
    endfunction

    function automatic logic elem_is_down(input logic [2:0] alg, input logic [2:0] idx);
        elem_t e;
        e = elem_lookup(alg, idx);
        return e.down;
    endfunction

endpackage

// File: rtl/sbist_bgen.sv
module sbist_bgen
    import sbist_pkg::*;
#(
    parameter int DW = 4
) (
    input  bg_e           bg,
    input  logic          odd,
    output logic [DW-1:0] word
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        localparam logic EVEN_BIT = ((i % 2) == 0);
        assign word[i] = (bg == BG_ZERO) ? 1'b0 :
                         (bg == BG_ONE)  ? 1'b1 :
                         (bg == BG_CHK)  ? (EVEN_BIT ^ odd) :
                                           ~(EVEN_BIT ^ odd);
    end
endmodule

// File: rtl/sbist_addr_gen.sv
module sbist_addr_gen #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          load_down,
    input  logic          step,
    input  logic          dir_down,
    output logic [AW-1:0] addr,
    output logic          at_end
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_down ? '1 : '0;
        end else if (step) begin
            addr <= dir_down ? addr - 1'b1 : addr + 1'b1;
        end
    end

    assign at_end = dir_down ? (addr == '0) : (&addr);
endmodule

// File: rtl/sbist_compare.sv
module sbist_compare #(
    parameter int AW = 8,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_rd,
    input  logic [AW-1:0] issue_addr,
    input  logic [DW-1:0] issue_exp,
    input  logic [DW-1:0] rdata,
    output logic          fail,
    output logic [AW-1:0] fail_addr
);
    logic          cmp_vld;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] exp_q;
    logic          mismatch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_vld <= 1'b0;
            addr_q  <= '0;
            exp_q   <= '0;
        end else begin
            cmp_vld <= issue_rd;
            addr_q  <= issue_addr;
            exp_q   <= issue_exp;
        end
    end

    assign mismatch = cmp_vld && (rdata != exp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail      <= 1'b0;
            fail_addr <= '0;
        end else if (mismatch && !fail) begin
            fail      <= 1'b1;
            fail_addr <= addr_q;
        end
    end
endmodule

// File: rtl/sbist_port_mux.sv
module sbist_port_mux #(
    parameter int AW = 8,
    parameter int DW = 4
) (
    input  logic          sel_fn,
    input  logic [AW-1:0] bist_addr,
    input  logic [DW-1:0] bist_wdata,
    input  logic          bist_we,
    input  logic [AW-1:0] fn_addr,
    input  logic [DW-1:0] fn_wdata,
    input  logic          fn_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we
);
    always_comb begin
        if (sel_fn) begin
            mem_addr  = fn_addr;
            mem_wdata = fn_wdata;
            mem_we    = fn_we;
        end else begin
            mem_addr  = bist_addr;
            mem_wdata = bist_wdata;
            mem_we    = bist_we;
        end
    end
endmodule

// File: rtl/sram_bist_ctrl.sv
module sram_bist_ctrl
    import sbist_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    alg_sel,
    input  logic [AW-1:0] fn_addr,
    input  logic [DW-1:0] fn_wdata,
    input  logic          fn_we,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr
);
    st_e           state, state_nx;
    logic [2:0]    alg_q;
    logic [2:0]    el_idx;
    logic [1:0]    op_idx;
    elem_t         cur_el;
    op_t           cur_op;
    logic          last_op_hit;
    logic          at_end;
    logic          elem_done;
    logic [AW-1:0] addr;
    logic [DW-1:0] bg_word;
    logic          ag_load, ag_load_down, ag_step;
    logic          bist_we, issue_rd, sel_fn;

    assign cur_el      = elem_lookup(alg_q, el_idx);
    assign cur_op      = cur_el.ops[op_idx];
    assign last_op_hit = (op_idx == cur_el.last_op);
    assign elem_done   = (state == ST_RUN) && last_op_hit && at_end;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = ST_RUN;
            ST_RUN:   if (elem_done && cur_el.final_el) state_nx = ST_DRAIN;
            ST_DRAIN: state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_DONE;
        endcase
    end

    // outputs
    always_comb begin
        bist_we  = 1'b0;
        issue_rd = 1'b0;
        sel_fn   = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_RUN: begin
                bist_we  = cur_op.wr;
                issue_rd = ~cur_op.wr;
            end
            ST_DRAIN: ;
            ST_DONE:  sel_fn = 1'b1;
        endcase
    end
    assign done = (state == ST_DONE);

    // sequence counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alg_q  <= '0;
            el_idx <= '0;
            op_idx <= '0;
        end else if (state == ST_IDLE) begin
            alg_q  <= alg_sel;
            el_idx <= '0;
            op_idx <= '0;
        end else if (state == ST_RUN) begin
            if (last_op_hit) begin
                op_idx <= '0;
                if (at_end && !cur_el.final_el) el_idx <= el_idx + 3'd1;
            end else begin
                op_idx <= op_idx + 2'd1;
            end
        end
    end

    assign ag_load      = (state == ST_IDLE) || (elem_done && !cur_el.final_el);
    assign ag_load_down = (state == ST_IDLE) ? elem_is_down(alg_sel, 3'd0)
                                             : elem_is_down(alg_q, el_idx + 3'd1);
    assign ag_step      = (state == ST_RUN) && last_op_hit && !at_end;

    sbist_addr_gen #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ag_load),
        .load_down (ag_load_down),
        .step      (ag_step),
        .dir_down  (cur_el.down),
        .addr      (addr),
        .at_end    (at_end)
    );

    sbist_bgen #(.DW(DW)) u_bg (
        .bg   (cur_op.bg),
        .odd  (addr[0]),
        .word (bg_word)
    );

    sbist_compare #(.AW(AW), .DW(DW)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_rd   (issue_rd),
        .issue_addr (addr),
        .issue_exp  (bg_word),
        .rdata      (mem_rdata),
        .fail       (fail),
        .fail_addr  (fail_addr)
    );

    sbist_port_mux #(.AW(AW), .DW(DW)) u_mux (
        .sel_fn     (sel_fn),
        .bist_addr  (addr),
        .bist_wdata (bg_word),
        .bist_we    (bist_we),
        .fn_addr    (fn_addr),
        .fn_wdata   (fn_wdata),
        .fn_we      (fn_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we)
    );
endmodule

// File: rtl/sbist_checker.sv
module sbist_checker #(
    parameter int AW = 8,
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          fail,
    input logic [AW-1:0] fail_addr,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_we,
    input logic [AW-1:0] fn_addr,
    input logic [DW-1:0] fn_wdata,
    input logic          fn_we
);
    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R10
    done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(!mem_we));

    // R9
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> fail);

    // R9
    fail_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fail) |-> $stable(fail_addr));

    // R11
    handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_addr == fn_addr && mem_wdata == fn_wdata && mem_we == fn_we));
endmodule

bind sram_bist_ctrl sbist_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .fn_addr   (fn_addr),
    .fn_wdata  (fn_wdata),
    .fn_we     (fn_we)
);

// File: tb/sim_sram_bist_ctrl.sv
module sim_sram_bist_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 4;
    localparam int DEPTH = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    alg_sel = 3'd0;
    logic [AW-1:0] fn_addr = '0;
    logic [DW-1:0] fn_wdata = '0;
    logic          fn_we = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic          done, fail;
    logic [AW-1:0] fail_addr;

    sram_bist_ctrl #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .alg_sel(alg_sel),
        .fn_addr(fn_addr), .fn_wdata(fn_wdata), .fn_we(fn_we),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .done(done), .fail(fail), .fail_addr(fail_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // fault configuration: stuck-at bits seen on read
    bit   f_on [2];
    int   f_addr [2];
    int   f_bit [2];
    logic f_val [2];

    function automatic logic [DW-1:0] faulted(input int a, input logic [DW-1:0] v);
        logic [DW-1:0] r;
        r = v;
        for (int k = 0; k < 2; k++)
            if (f_on[k] && a == f_addr[k]) r[f_bit[k]] = f_val[k];
        return r;
    endfunction

    // memory model
    logic [DW-1:0] mem [DEPTH];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= faulted(int'(mem_addr), mem[mem_addr]);
    end

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            summary();
            $finish;
        end
    end

    // reference operation list
    bit            q_we [$];
    int            q_addr [$];
    logic [DW-1:0] q_data [$];

    function automatic logic [DW-1:0] bgv(input byte c, input int a);
        case (c)
            "1":     return 4'hF;
            "c":     return (a % 2) ? 4'hA : 4'h5;
            "i":     return (a % 2) ? 4'h5 : 4'hA;
            default: return 4'h0;
        endcase
    endfunction

    task automatic add_elem(input bit down, input string ops);
        for (int s = 0; s < DEPTH; s++) begin
            int a;
            a = down ? (DEPTH - 1 - s) : s;
            for (int k = 0; k < ops.len(); k += 2) begin
                q_we.push_back(ops[k] == "w");
                q_addr.push_back(a);
                q_data.push_back(bgv(ops[k+1], a));
            end
        end
    endtask

    task automatic build_ref(input int code);
        q_we.delete(); q_addr.delete(); q_data.delete();
        case (code)
            1: begin add_elem(0, "w1"); add_elem(0, "r1"); end
            2: begin add_elem(0, "wc"); add_elem(0, "rc"); end
            3: begin add_elem(0, "wi"); add_elem(0, "ri"); end
            4: begin
                add_elem(0, "w0"); add_elem(0, "r0w1"); add_elem(0, "r1w0");
                add_elem(1, "r0w1"); add_elem(1, "r1w0"); add_elem(0, "r0");
            end
            5: begin
                add_elem(0, "w0"); add_elem(1, "r0w1"); add_elem(0, "r1w0r0w1");
                add_elem(0, "r1w0"); add_elem(0, "r0w1r1w0"); add_elem(0, "r0");
            end
            default: begin add_elem(0, "w0"); add_elem(0, "r0"); end
        endcase
    endtask

    task automatic do_run(input int code, input string tag);
        bit exp_fail;
        int exp_addr;
        rst_n = 1'b0;
        alg_sel = 3'(code);
        fn_we = 1'b1; fn_addr = 8'h33; fn_wdata = 4'h9;
        for (int a = 0; a < DEPTH; a++) mem[a] = 4'h6;
        repeat (2) @(posedge clk);
        #2;
        chk(done == 1'b0 && fail == 1'b0, "R1", "done/fail in reset", {done, fail}, 0);
        chk(mem_we == 1'b0, "R1", "mem_we in reset", mem_we, 0);
        build_ref(code);
        exp_fail = 1'b0;
        exp_addr = 0;
        for (int i = 0; i < q_we.size(); i++) begin
            if (!q_we[i] && !exp_fail && faulted(q_addr[i], q_data[i]) != q_data[i]) begin
                exp_fail = 1'b1;
                exp_addr = q_addr[i];
            end
        end
        rst_n = 1'b1;
        @(posedge clk);
        for (int i = 0; i < q_we.size(); i++) begin
            #1;
            fn_addr = AW'($urandom); fn_wdata = DW'($urandom); fn_we = 1'($urandom);
            if (i == 0) alg_sel = ~alg_sel;
            #1;
            chk(mem_we == q_we[i] && int'(mem_addr) == q_addr[i] &&
                (!q_we[i] || mem_wdata == q_data[i]),
                {tag, " R2 R12"}, $sformatf("op %0d we/addr/data", i),
                {mem_we, mem_addr, mem_wdata}, {q_we[i], q_addr[i][AW-1:0], q_data[i]});
            if (i == q_we.size() - 1)
                chk(done == 1'b0, "R10", "done during run", done, 0);
            @(posedge clk);
        end
        #2;
        chk(done == 1'b0, "R10", "done in compare cycle", done, 0);
        @(posedge clk);
        #2;
        chk(done == 1'b1, "R10", "done after last compare", done, 1);
        chk(fail == exp_fail, "R8", "fail flag", fail, exp_fail);
        if (exp_fail)
            chk(int'(fail_addr) == exp_addr, "R9", "first fail address", fail_addr, exp_addr);
        fn_we = 1'b1; fn_addr = 8'hA5; fn_wdata = 4'hC;
        #1;
        chk(mem_we && mem_addr == 8'hA5 && mem_wdata == 4'hC, "R11", "port handoff",
            {mem_we, mem_addr, mem_wdata}, {1'b1, 8'hA5, 4'hC});
        @(posedge clk);
        #1;
        fn_we = 1'b0;
        @(posedge clk);
        #2;
        chk(mem_rdata == faulted(8'hA5, 4'hC), "R11", "functional readback",
            mem_rdata, faulted(8'hA5, 4'hC));
        chk(done == 1'b1 && fail == exp_fail, "R10", "done/fail held", {done, fail}, {1'b1, exp_fail});
    endtask

    task automatic clear_faults();
        for (int k = 0; k < 2; k++) f_on[k] = 1'b0;
    endtask

    initial begin
        clear_faults();
        do_run(0, "R3");
        do_run(1, "R3");
        do_run(2, "R4");
        do_run(3, "R4");
        do_run(4, "R5");
        do_run(5, "R6");
        do_run(6, "R7");
        do_run(7, "R7");
        // R9: earlier read in operation order wins
        f_on[0] = 1; f_addr[0] = 37;  f_bit[0] = 1; f_val[0] = 1'b1;
        f_on[1] = 1; f_addr[1] = 200; f_bit[1] = 3; f_val[1] = 1'b0;
        do_run(4, "R5");
        // R9: descending element reports higher address first
        f_on[0] = 1; f_addr[0] = 5;   f_bit[0] = 0; f_val[0] = 1'b0;
        f_on[1] = 1; f_addr[1] = 250; f_bit[1] = 2; f_val[1] = 1'b1;
        do_run(5, "R6");
        // R8: stuck bit agreeing with checkerboard is invisible, visible for inverse
        clear_faults();
        f_on[0] = 1; f_addr[0] = 9; f_bit[0] = 0; f_val[0] = 1'b0;
        do_run(2, "R4");
        do_run(3, "R4");
        // R8: last address
        clear_faults();
        f_on[0] = 1; f_addr[0] = 255; f_bit[0] = 3; f_val[0] = 1'b0;
        do_run(1, "R3");
        summary();
        $finish;
    end
endmodule